// File: doc/BRIEF.md
# Line Buffer Scanout and Register File

This block is the register side of a scanline video engine. It holds a 64-slot register file written and read by the CPU. Among those slots are one background colour and eight palettes of three colours each. The palette slots are interleaved with control slots, so a 5-bit colour index stored in the line buffer is also the offset of its colour register above the background slot. The block decodes the control register into the mode signals the display-list fetcher needs. It reports vertical blanking through a status register, holds a one-time configuration lock, and raises a CPU wait request that lasts until the next line begins.

The block counts CPU cycles into lines of 114 cycles and lines into a frame. At the start of every line it walks the external line buffer from its first entry to its last, one entry per clock. It turns each of the first `VIS_PITCH` entries into a colour through the palette registers and writes zero back into every entry it visits. This leaves the buffer empty for the fetcher to fill for the next line.

Top module: `vidline_regs`

## Requirements
- R1: Only the low six bits of `cpuAddr` select a register; the upper bits have no effect on reads or writes.
- R2: A write to a slot other than 0x24 (sync wait), 0x28 (status) or 0x38 (reserved) stores the byte, and a read returns it one clock after `cpuRdEn`. Writes to those three slots are not stored: slots 0x24 and 0x38 read 0, and slot 0x28 always reads the blanking status.
- R3: Each scanned pixel uses only bits 4:0 of its line-buffer entry as the index. When index bits 1:0 are 00 the pixel is the background register (slot 0x20); otherwise it is the register at slot 0x20 + index.
- R4: A line starts on a `frameStart` pulse or after the last cycle of a 114-cycle line. In the following clocks `lbAddr` steps 0,1,...,`LB_DEPTH`-1 with `lbClr` high. A pixel appears on `pixColour` with `pixValid` one clock after each of the addresses below `VIS_PITCH`, and nowhere else.
- R5: Every line-buffer entry visited by the scan is written to zero, including those beyond `VIS_PITCH`.
- R6: When a palette register is written in the same clock in which the scan reads an entry that uses it, that pixel shows the old value and later pixels show the new value.
- R7: The control register (slot 0x3C) decodes as follows: bit 7 colour kill; DMA enabled only when bits 6:5 are 10; bit 4 double-width characters; bit 3 border control; bit 2 opaque-zero mode; bits 1:0 read mode.
- R8: The status register reads 0x80 on lines below 11 and on lines at or above 11+242 (`palMode`=0) or 11+292 (`palMode`=1), and 0x00 on the lines between.
- R9: In slot 0x01, bits 3:1 appear on `portCfg`. Writing bit 0 as 1 sets `ctlLocked`, and from then on writes to slot 0x01 are ignored until reset.
- R10: A write to slot 0x24 raises `cpuWait` on the next clock. It stays high until a line starts, except that a write in the same clock as a line start keeps it high for the whole next line.
- R11: The cycle position counts 0..113 per `cpuTick` and the line number advances when it wraps; `frameStart` returns both to zero.
- R12: Reset clears all registers, the lock, the wait request and the scan, so that DMA is disabled and all control fields and the read mode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuTick | input | 1 | One CPU cycle elapsed |
| frameStart | input | 1 | Start of frame: line 0, position 0, new scan |
| palMode | input | 1 | 1 selects the 312-line frame timing |
| cpuAddr | input | CPU_AW | CPU register address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuRdEn | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | Read data, valid the clock after the strobe |
| lbAddr | output | log2(LB_DEPTH) | Line-buffer address being scanned |
| lbRdData | input | 8 | Line-buffer entry at `lbAddr` (combinational read) |
| lbClr | output | 1 | Write zero to the entry at `lbAddr` this clock |
| pixValid | output | 1 | `pixColour` holds a pixel |
| pixColour | output | 8 | Looked-up pixel colour |
| cpuWait | output | 1 | Hold the CPU until the next line |
| dmaEn | output | 1 | Display-list DMA enabled |
| readMode | output | 2 | Graphics read mode |
| colourKill | output | 1 | Colour kill |
| dblWidth | output | 1 | Double-width characters |
| borderCtl | output | 1 | Border control |
| opaqueZero | output | 1 | Zero pixels overwrite the line buffer |
| portCfg | output | 3 | Configuration bits 3:1 of slot 0x01 |
| ctlLocked | output | 1 | Configuration lock set |

## Verification
The scan read of a palette register and a CPU write to that same register can land in one clock. The bench fills a line with index 1, aims a write to slot 0x21 at the clock in which address 10 is scanned, and expects pixel 10 to carry the old colour and pixel 11 the new one. A second collision is a sync-wait write in the last cycle of a line. There the set must win over the line-start release, so the bench expects `cpuWait` to stay high for 114 more cycles.

// File: rtl/vidline_pkg.sv
package vidline_pkg;
  localparam int REG_AW    = 6;
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int DATA_W    = 8;

  localparam logic [REG_AW-1:0] ADDR_PORTCTL  = 6'h01;
  localparam logic [REG_AW-1:0] ADDR_BKGND    = 6'h20;
  localparam logic [REG_AW-1:0] ADDR_SYNC     = 6'h24;
  localparam logic [REG_AW-1:0] ADDR_STATUS   = 6'h28;
  localparam logic [REG_AW-1:0] ADDR_RESERVED = 6'h38;
  localparam logic [REG_AW-1:0] ADDR_CTRL     = 6'h3C;

  // Strobes from control to datapath
  typedef struct packed {
    logic              regWe;
    logic [REG_AW-1:0] regAddr;
    logic [DATA_W-1:0] regData;
    logic              rdEn;
    logic [REG_AW-1:0] rdAddr;
    logic              blanking;
    logic              pixEn;
  } strobe_t;

  typedef struct packed {
    logic       colourKill;
    logic       dmaEn;
    logic       dblWidth;
    logic       borderCtl;
    logic       opaqueZero;
    logic [1:0] readMode;
  } ctrl_t;

  function automatic ctrl_t decodeCtrl(input logic [DATA_W-1:0] v);
    ctrl_t c;
    c.colourKill = v[7];
    c.dmaEn      = (v[6:5] == 2'b10);
    c.dblWidth   = v[4];
    c.borderCtl  = v[3];
    c.opaqueZero = v[2];
    c.readMode   = v[1:0];
    return c;
  endfunction
endpackage

// File: rtl/vidline_ctl.sv
module vidline_ctl
  import vidline_pkg::*;
#(
  parameter int CPU_AW          = 16,
  parameter int LB_DEPTH        = 512,
  parameter int VIS_PITCH       = 320,
  parameter int CYCLES_PER_LINE = 114,
  parameter int FIRST_VIS       = 11,
  parameter int VIS_LINES_SHORT = 242,
  parameter int VIS_LINES_LONG  = 292,
  parameter int LINE_W          = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpuTick,
  input  logic                        frameStart,
  input  logic                        palMode,
  input  logic [CPU_AW-1:0]           cpuAddr,
  input  logic [DATA_W-1:0]           cpuWrData,
  input  logic                        cpuWrEn,
  input  logic                        cpuRdEn,
  output strobe_t                     strb,
  output logic [$clog2(LB_DEPTH)-1:0] lbAddr,
  output logic                        lbClr,
  output logic                        cpuWait,
  output logic                        ctlLocked
);
  localparam int LB_AW = $clog2(LB_DEPTH);
  localparam int HP_W  = $clog2(CYCLES_PER_LINE);
  localparam logic [HP_W-1:0]   HP_LAST   = HP_W'(CYCLES_PER_LINE - 1);
  localparam logic [LB_AW-1:0]  SCAN_LAST = LB_AW'(LB_DEPTH - 1);
  localparam logic [LINE_W-1:0] LINE_MAX  = '1;
  localparam logic [LINE_W:0]   VIS_FIRST = (LINE_W+1)'(FIRST_VIS);
  localparam logic [LINE_W:0]   VIS_END_S = (LINE_W+1)'(FIRST_VIS + VIS_LINES_SHORT);
  localparam logic [LINE_W:0]   VIS_END_L = (LINE_W+1)'(FIRST_VIS + VIS_LINES_LONG);
  localparam logic [LB_AW:0]    PITCH_LIM = (LB_AW+1)'(VIS_PITCH);

  logic [HP_W-1:0]   hPos;
  logic [LINE_W-1:0] lineNum;
  logic              scanActive;
  logic [LB_AW-1:0]  scanAddr;
  logic [REG_AW-1:0] regAddr;
  logic              lineEnd, lineStart, syncWr, portWr, storeOk;
  logic [LINE_W:0]   visEnd;
  logic              unusedAddrHi;

  assign regAddr      = cpuAddr[REG_AW-1:0];
  assign unusedAddrHi = ^cpuAddr[CPU_AW-1:REG_AW];
  assign lineEnd      = cpuTick && (hPos == HP_LAST);
  assign lineStart    = frameStart || lineEnd;
  assign syncWr       = cpuWrEn && (regAddr == ADDR_SYNC);
  assign portWr       = cpuWrEn && (regAddr == ADDR_PORTCTL);

  always_comb begin
    storeOk = 1'b1;
    if (regAddr == ADDR_SYNC || regAddr == ADDR_STATUS || regAddr == ADDR_RESERVED)
      storeOk = 1'b0;
    if (regAddr == ADDR_PORTCTL && ctlLocked)
      storeOk = 1'b0;
  end

  // Cycle and line counting
  always_ff @(posedge clk) begin
    if (rst || frameStart) begin
      hPos    <= '0;
      lineNum <= '0;
    end else if (cpuTick) begin
      if (hPos == HP_LAST) begin
        hPos <= '0;
        if (lineNum != LINE_MAX) lineNum <= lineNum + 1'b1;
      end else begin
        hPos <= hPos + 1'b1;
      end
    end
  end

  assign visEnd = palMode ? VIS_END_L : VIS_END_S;

  // Sync-wait request: a set in the line-start clock wins
  always_ff @(posedge clk) begin
    if (rst)            cpuWait <= 1'b0;
    else if (syncWr)    cpuWait <= 1'b1;
    else if (lineStart) cpuWait <= 1'b0;
  end

  // One-time configuration lock
  always_ff @(posedge clk) begin
    if (rst)                                      ctlLocked <= 1'b0;
    else if (portWr && !ctlLocked && cpuWrData[0]) ctlLocked <= 1'b1;
  end

  // Scan sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      scanActive <= 1'b0;
      scanAddr   <= '0;
    end else if (lineStart) begin
      scanActive <= 1'b1;
      scanAddr   <= '0;
    end else if (scanActive) begin
      if (scanAddr == SCAN_LAST) scanActive <= 1'b0;
      else                       scanAddr   <= scanAddr + 1'b1;
    end
  end

  assign lbAddr = scanAddr;
  assign lbClr  = scanActive;

  always_comb begin
    strb.regWe    = cpuWrEn && storeOk;
    strb.regAddr  = regAddr;
    strb.regData  = cpuWrData;
    strb.rdEn     = cpuRdEn;
    strb.rdAddr   = regAddr;
    strb.blanking = ({1'b0, lineNum} < VIS_FIRST) || ({1'b0, lineNum} >= visEnd);
    strb.pixEn    = scanActive && ({1'b0, scanAddr} < PITCH_LIM);
  end

  assert_hpos_range_R11: assert property (@(posedge clk) disable iff (rst)
    hPos <= HP_LAST);

  assert_wait_set_R10: assert property (@(posedge clk) disable iff (rst)
    syncWr |=> cpuWait);

  assert_wait_release_R10: assert property (@(posedge clk) disable iff (rst)
    (lineStart && !syncWr) |=> !cpuWait);

  assert_scan_step_R4: assert property (@(posedge clk) disable iff (rst)
    (scanActive && !lineStart && scanAddr != SCAN_LAST)
      |=> (scanActive && scanAddr == $past(scanAddr) + 1'b1));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ctlLocked |=> ctlLocked);

  assert_lock_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (ctlLocked && portWr) |-> !strb.regWe);
endmodule

// File: rtl/vidline_dp.sv
module vidline_dp
  import vidline_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] lbRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixColour,
  output ctrl_t             ctrl,
  output logic [2:0]        portCfg
);
  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [4:0]        colIdx;
  logic [REG_AW-1:0] colAddr;
  logic [2:0]        unusedEntryHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (strb.regWe) begin
      regFile[strb.regAddr] <= strb.regData;
    end
  end

  // Index bits 1:0 equal to zero select the background slot
  assign colIdx        = lbRdData[4:0];
  assign unusedEntryHi = lbRdData[7:5];
  assign colAddr       = (colIdx[1:0] == 2'b00) ? ADDR_BKGND : {1'b1, colIdx};

  always_ff @(posedge clk) begin
    if (rst) begin
      pixValid  <= 1'b0;
      pixColour <= '0;
    end else begin
      pixValid <= strb.pixEn;
      if (strb.pixEn) pixColour <= regFile[colAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpuRdData <= '0;
    end else if (strb.rdEn) begin
      if (strb.rdAddr == ADDR_STATUS) cpuRdData <= {strb.blanking, 7'b0};
      else                            cpuRdData <= regFile[strb.rdAddr];
    end
  end

  assign ctrl    = decodeCtrl(regFile[ADDR_CTRL]);
  assign portCfg = regFile[ADDR_PORTCTL][3:1];

  assert_pix_after_scan_R4: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> $past(strb.pixEn));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(strb.regWe && strb.regAddr == ADDR_CTRL) |=> $stable(regFile[ADDR_CTRL]));
endmodule

// File: rtl/vidline_regs.sv
module vidline_regs
  import vidline_pkg::*;
#(
  parameter int CPU_AW          = 16,
  parameter int LB_DEPTH        = 512,
  parameter int VIS_PITCH       = 320,
  parameter int CYCLES_PER_LINE = 114,
  parameter int FIRST_VIS       = 11,
  parameter int VIS_LINES_SHORT = 242,
  parameter int VIS_LINES_LONG  = 292,
  parameter int LINE_W          = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpuTick,
  input  logic                        frameStart,
  input  logic                        palMode,
  input  logic [CPU_AW-1:0]           cpuAddr,
  input  logic [7:0]                  cpuWrData,
  input  logic                        cpuWrEn,
  input  logic                        cpuRdEn,
  output logic [7:0]                  cpuRdData,
  output logic [$clog2(LB_DEPTH)-1:0] lbAddr,
  input  logic [7:0]                  lbRdData,
  output logic                        lbClr,
  output logic                        pixValid,
  output logic [7:0]                  pixColour,
  output logic                        cpuWait,
  output logic                        dmaEn,
  output logic [1:0]                  readMode,
  output logic                        colourKill,
  output logic                        dblWidth,
  output logic                        borderCtl,
  output logic                        opaqueZero,
  output logic [2:0]                  portCfg,
  output logic                        ctlLocked
);
  strobe_t strb;
  ctrl_t   ctrl;

  vidline_ctl #(
    .CPU_AW(CPU_AW), .LB_DEPTH(LB_DEPTH), .VIS_PITCH(VIS_PITCH),
    .CYCLES_PER_LINE(CYCLES_PER_LINE), .FIRST_VIS(FIRST_VIS),
    .VIS_LINES_SHORT(VIS_LINES_SHORT), .VIS_LINES_LONG(VIS_LINES_LONG),
    .LINE_W(LINE_W)
  ) uCtl (
    .clk(clk), .rst(rst), .cpuTick(cpuTick), .frameStart(frameStart),
    .palMode(palMode), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .strb(strb), .lbAddr(lbAddr),
    .lbClr(lbClr), .cpuWait(cpuWait), .ctlLocked(ctlLocked)
  );

  vidline_dp uDp (
    .clk(clk), .rst(rst), .strb(strb), .lbRdData(lbRdData),
    .cpuRdData(cpuRdData), .pixValid(pixValid), .pixColour(pixColour),
    .ctrl(ctrl), .portCfg(portCfg)
  );

  assign dmaEn      = ctrl.dmaEn;
  assign readMode   = ctrl.readMode;
  assign colourKill = ctrl.colourKill;
  assign dblWidth   = ctrl.dblWidth;
  assign borderCtl  = ctrl.borderCtl;
  assign opaqueZero = ctrl.opaqueZero;
endmodule

// File: tb/vidline_regs_test.sv
module vidline_regs_test;
  localparam int LBD = 64;
  localparam int PIT = 48;
  localparam int NV  = 12;
  // {line-buffer entry, expected colour}; palette slot 0x20+i holds 0x80+i, background 0x55
  localparam logic [15:0] VEC [NV] = '{
    16'h0055, 16'h0181, 16'h0282, 16'h0383, 16'h0585, 16'h0E8E,
    16'h1393, 16'h1F9F, 16'h1C55, 16'h0855, 16'hE181, 16'h7B9B
  };

  logic clk = 0, rst = 1, cpuTick = 1, frameStart = 0, palMode = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuWrData = 0;
  logic cpuWrEn = 0, cpuRdEn = 0;
  logic [7:0] cpuRdData, lbRdData, pixColour;
  logic [5:0] lbAddr;
  logic lbClr, pixValid, cpuWait, dmaEn, colourKill, dblWidth, borderCtl, opaqueZero, ctlLocked;
  logic [1:0] readMode;
  logic [2:0] portCfg;

  logic [7:0] lbMem [LBD];
  logic [7:0] lbPat [LBD];
  logic [7:0] pixBuf [LBD];
  logic tbLoadAll = 0;
  int nChecks = 0, nErr = 0, cur = 0;

  always #10 clk = ~clk;

  vidline_regs #(.LB_DEPTH(LBD), .VIS_PITCH(PIT)) uut (
    .clk(clk), .rst(rst), .cpuTick(cpuTick), .frameStart(frameStart), .palMode(palMode),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuRdData(cpuRdData), .lbAddr(lbAddr), .lbRdData(lbRdData), .lbClr(lbClr),
    .pixValid(pixValid), .pixColour(pixColour), .cpuWait(cpuWait), .dmaEn(dmaEn),
    .readMode(readMode), .colourKill(colourKill), .dblWidth(dblWidth),
    .borderCtl(borderCtl), .opaqueZero(opaqueZero), .portCfg(portCfg), .ctlLocked(ctlLocked)
  );

  // Line-buffer model: bulk load has priority over the scan clear
  always @(posedge clk) begin
    if (tbLoadAll) begin
      for (int k = 0; k < LBD; k++) lbMem[k] <= lbPat[k];
    end else if (lbClr) begin
      lbMem[lbAddr] <= 8'h00;
    end
  end
  assign lbRdData = lbMem[lbAddr];

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1;
    @(negedge clk);
    cpuWrEn = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    cpuAddr = a; cpuRdEn = 1;
    @(negedge clk);
    cpuRdEn = 0;
    v = cpuRdData;
  endtask

  task automatic doReset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic startFrame();
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
    cur = 0;
  endtask

  task automatic waitTo(input int n);
    repeat (n - cur) @(negedge clk);
    cur = n;
  endtask

  task automatic statusAt(input int line, input int exp, input string tag);
    logic [7:0] v;
    waitTo(114 * line + 5);
    rd(16'h0028, v);
    cur++;
    chk(tag, v, exp);
  endtask

  // Load lbPat and start a line; collect pixels. Optional write in scan clock injK.
  task automatic runLine(input int injK, input logic [15:0] injA, input logic [7:0] injD,
                         output int n);
    int seqOk;
    seqOk = 1;
    tbLoadAll = 1; frameStart = 1;
    @(negedge clk);
    tbLoadAll = 0; frameStart = 0;
    n = 0;
    for (int c = 0; c < 70; c++) begin
      if (c < LBD) begin
        if (lbAddr != 6'(c) || !lbClr) seqOk = 0;
      end else if (lbClr) seqOk = 0;
      if (c == injK) begin
        cpuAddr = injA; cpuWrData = injD; cpuWrEn = 1;
      end else begin
        cpuWrEn = 0;
      end
      @(negedge clk);
      if (pixValid && n < LBD) begin
        pixBuf[n] = pixColour;
        n++;
      end
    end
    cpuWrEn = 0;
    cur = 70;
    chk("R4 scan address order and lbClr window", seqOk, 1);
  endtask

  initial begin
    logic [7:0] v;
    int n, ok;
    for (int k = 0; k < LBD; k++) begin lbMem[k] = 0; lbPat[k] = 0; end
    doReset();

    // R12 reset state
    chk("R12 cpuWait after reset", cpuWait, 0);
    chk("R12 control fields after reset",
        {colourKill, dmaEn, dblWidth, borderCtl, opaqueZero, readMode}, 0);
    chk("R12 lock after reset", {ctlLocked, portCfg}, 0);
    chk("R12 no scan after reset", {lbClr, pixValid}, 0);
    rd(16'h0028, v);
    chk("R8 status on line 0 after reset", v, 8'h80);

    // R1 / R2 decode and storage
    wr(16'hA7E1, 8'h4C);
    rd(16'h0061, v);
    chk("R1 upper address bits ignored", v, 8'h4C);
    wr(16'h1234, 8'h5A);
    rd(16'h0034, v);
    chk("R2 register readback", v, 8'h5A);
    wr(16'h0038, 8'hFF);
    rd(16'h0038, v);
    chk("R2 reserved slot reads zero", v, 0);
    wr(16'h0024, 8'hA5);
    rd(16'h0024, v);
    chk("R2 sync slot reads zero", v, 0);

    // Palette setup
    wr(16'h0020, 8'h55);
    for (int i = 1; i < 32; i++)
      if (i % 4 != 0) wr(16'(32 + i), 8'(8'h80 + i));

    // R3 table walk
    for (int k = 0; k < LBD; k++) lbPat[k] = VEC[k % NV][15:8];
    runLine(-1, 16'h0, 8'h0, n);
    chk("R4 visible pixel count", n, PIT);
    for (int vi = 0; vi < NV; vi++) begin
      ok = 1;
      for (int k = vi; k < PIT; k += NV)
        if (pixBuf[k] !== VEC[vi][7:0]) ok = 0;
      chk($sformatf("R3 lookup of entry 0x%0h", VEC[vi][15:8]), ok ? VEC[vi][7:0] : pixBuf[vi],
          VEC[vi][7:0]);
    end
    ok = 1;
    for (int k = 0; k < LBD; k++) if (lbMem[k] != 0) ok = 0;
    chk("R5 every entry cleared", ok, 1);

    // R11 / R4 natural line restart after 114 cycles
    waitTo(113);
    chk("R11 no scan in last cycle of line", lbClr, 0);
    waitTo(114);
    chk("R11 scan restarts at next line", {lbClr, 2'b00, lbAddr}, 9'h100);

    // R6 palette write colliding with scan of address 10
    for (int k = 0; k < LBD; k++) lbPat[k] = 8'h01;
    runLine(10, 16'h0021, 8'h3A, n);
    chk("R6 pixel in write clock keeps old colour", pixBuf[10], 8'h81);
    chk("R6 next pixel uses new colour", pixBuf[11], 8'h3A);
    chk("R6 earlier pixel", pixBuf[0], 8'h81);

    // R7 control decode {colourKill,dmaEn,dblWidth,borderCtl,opaqueZero,readMode}
    wr(16'h003C, 8'h5F);
    chk("R7 ctrl 0x5F", {colourKill, dmaEn, dblWidth, borderCtl, opaqueZero, readMode}, 7'b0111111);
    wr(16'h003C, 8'h60);
    chk("R7 ctrl 0x60 dma off", {colourKill, dmaEn, dblWidth, borderCtl, opaqueZero, readMode}, 0);
    wr(16'h003C, 8'h20);
    chk("R7 ctrl 0x20 dma off", dmaEn, 0);
    wr(16'h003C, 8'hC2);
    chk("R7 ctrl 0xC2", {colourKill, dmaEn, dblWidth, borderCtl, opaqueZero, readMode}, 7'b1100010);

    // R9 lock
    wr(16'h0001, 8'h06);
    chk("R9 unlocked write", {ctlLocked, portCfg}, 4'b0011);
    wr(16'h0001, 8'h0B);
    chk("R9 locking write", {ctlLocked, portCfg}, 4'b1101);
    wr(16'h0001, 8'h0E);
    chk("R9 write after lock ignored", {ctlLocked, portCfg}, 4'b1101);
    rd(16'h0001, v);
    chk("R9 locked readback", v, 8'h0B);
    doReset();
    chk("R12 reset clears lock and control", {ctlLocked, portCfg, dmaEn, readMode}, 0);
    wr(16'h0001, 8'h04);
    chk("R9 write accepted after reset", {ctlLocked, portCfg}, 4'b0010);

    // R10 sync wait
    startFrame();
    waitTo(50);
    wr(16'h0024, 8'h00); cur++;
    chk("R10 wait raised", cpuWait, 1);
    waitTo(113);
    chk("R10 wait held to end of line", cpuWait, 1);
    waitTo(114);
    chk("R10 wait released at line start", cpuWait, 0);
    waitTo(227);
    wr(16'h0024, 8'h00); cur++;
    chk("R10 set wins over line start", cpuWait, 1);
    waitTo(341);
    chk("R10 held through following line", cpuWait, 1);
    waitTo(342);
    chk("R10 released one line later", cpuWait, 0);

    // R8 status, short frame
    palMode = 0;
    startFrame();
    statusAt(10, 8'h80, "R8 short frame line 10");
    statusAt(11, 8'h00, "R8 short frame line 11");
    statusAt(252, 8'h00, "R8 short frame line 252");
    statusAt(253, 8'h80, "R8 short frame line 253");
    // R8 status, long frame
    palMode = 1;
    startFrame();
    statusAt(253, 8'h00, "R8 long frame line 253");
    statusAt(302, 8'h00, "R8 long frame line 302");
    statusAt(303, 8'h80, "R8 long frame line 303");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule